// File: doc/BRIEF.md
# Dual-Clock FIFO with Mark-and-Rewind Read

This block moves data words from a producer in one clock domain (port A) to a consumer in a second, independent clock domain (port B). The two clocks may be unrelated or identical. Storage is an inferred register array. Write and read pointers cross between the domains as Gray codes through two-flop synchronizers, so every flag is computed from a local pointer and a delayed copy of the remote one. Flags therefore err on the safe side: the write side may report less room than exists, and the read side may report fewer words than exist.

Port A writes when its chip select is low, its enable is high, its direction select is high and `a_ir` is high. `a_ir` acts as ready: a write attempt while it is low is dropped with no effect. Port B reads when its chip select is low, its enable is high, its direction select is high and `b_or` is high. `b_or` acts as valid: the word on `b_data` is held unchanged until it is taken, and a read attempt while it is low is dropped. A new word reaches `b_data` on the third `b_clk` edge after it was written into an empty FIFO. The almost-empty and almost-full thresholds come from outside the block and are expected to stay static while traffic flows.

For retransmission, the consumer can mark the word currently on `b_data` and later rewind the read pointer to it. While the mark is held, the marked word and everything after it are protected from being overwritten, so `a_ir` drops once the writer reaches the marked location.

Top module: `rtx_fifo`

## Requirements
- R1: While `rst_n` is low, `a_ir` and `b_or` are low. A reset completes only after `rst_n` has been low for at least four rising edges of each clock; `a_ir` then rises on the first `a_clk` edge after `rst_n` goes high. A reset held low for fewer than four edges leaves `a_ir` low.
- R2: A word is written on a rising `a_clk` edge only when `a_cs_n`=0, `a_en`=1, `a_wr`=1 and `a_ir`=1. Any other combination has no effect on the stored data.
- R3: A word is consumed on a rising `b_clk` edge only when `b_cs_n`=0, `b_en`=1, `b_wr_n`=1 and `b_or`=1. With `b_wr_n`=0 (write direction on port B) nothing is consumed. After the last stored word is consumed, `b_or` goes low.
- R4: After a word is written into an empty FIFO, `b_or` is high and the word is on `b_data` after the third rising `b_clk` edge that follows the write edge, and not before.
- R5: Words leave port B in the order they entered port A. `b_data` stays stable while `b_or` is high and no read takes place.
- R6: `b_ae_n` is low when the number of stored words, including the one on `b_data`, is less than or equal to `ae_thr`, and high otherwise.
- R7: `a_af_n` is low when the number of free locations is less than or equal to `af_thr`, and high otherwise.
- R8: With DEPTH words stored, including the one on `b_data`, `a_ir` is low and write attempts are ignored.
- R9: Read attempts while `b_or` is low are ignored and leave the read pointer unchanged.
- R10: On a `b_clk` edge with `b_rtm`=1, `b_or`=1 and retransmit mode off, the word on `b_data` becomes the mark and retransmit mode turns on. This also applies if that word is read on the same edge. Any `b_clk` edge with `b_rtm`=0 turns the mode off, and `b_rfm` then has no effect.
- R11: In retransmit mode, a `b_clk` edge with `b_rfm`=1 puts the marked word on `b_data`, sets `b_or` high, and continues reading from the word that follows the mark.
- R12: In retransmit mode, the write side treats the mark as the oldest word: `a_ir` goes low once DEPTH words, counted from the mark, are held. Reading does not raise it again until the mode is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Write-side clock |
| b_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, seen synchronously by both domains |
| a_cs_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A enable, active high |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_data | input | DW | Write data |
| a_ir | output | 1 | Input ready (room for a word) |
| a_af_n | output | 1 | Almost full, active low |
| af_thr | input | AW+1 | Almost-full free-location threshold |
| b_cs_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B enable, active high |
| b_wr_n | input | 1 | Port B direction, 1 = read, 0 = write (no FIFO effect) |
| b_data | output | DW | Read data (output register) |
| b_or | output | 1 | Output ready (valid word on b_data) |
| b_ae_n | output | 1 | Almost empty, active low |
| ae_thr | input | AW+1 | Almost-empty word-count threshold |
| b_rtm | input | 1 | Retransmit mode request |
| b_rfm | input | 1 | Rewind to mark |

## Verification
The functions that coincide are the mark and an ordinary read: on one `b_clk` edge the consumer takes the word on `b_data` while also asserting `b_rtm`, so the word is marked at the moment it leaves. The bench then reads two more words and pulses `b_rfm`. A correct design shows the consumed word again, followed by its successors. It also stops the writer exactly DEPTH words after the mark. A mark taken one word late shows up as a wrong rewound value and a writer that stops one word late.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;
  // number of edges each domain must see with reset held low
  localparam int RST_EDGES = 4;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_LOAD,
    RD_REWIND
  } rd_act_e;
endpackage

// File: rtl/rtx_fifo_rstseq.sv
module rtx_fifo_rstseq #(
  parameter int EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [EDGES-1:0] seen;

  // ones shift in while reset is low; the domain runs only once all are set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= {seen[EDGES-2:0], 1'b1};
      run  <= 1'b0;
    end else if (run) begin
      seen <= '0;
    end else if (&seen) begin
      run <= 1'b1;
    end
  end
endmodule

// File: rtl/rtx_fifo_gsync.sv
module rtx_fifo_gsync #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] gin,
  output logic [N-1:0] bout
);
  logic [N-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gin;
      s2 <= s1;
    end
  end

  // Gray to binary: each bit is the parity of itself and all higher bits
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign bout[i] = ^s2[N-1:i];
  end
endmodule

// File: rtl/rtx_fifo_wside.sv
module rtx_fifo_wside #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        req,
  input  logic [AW:0] psync,
  input  logic [AW:0] thr,
  output logic [AW:0] wptr,
  output logic [AW:0] wgray,
  output logic        ir,
  output logic        af_n,
  output logic        we
);
  localparam logic [AW:0] DEPTH = {1'b1, {AW{1'b0}}};

  logic [AW:0] used, free, nxt;

  assign used = wptr - psync;
  assign free = DEPTH - used;
  assign ir   = run && (used != DEPTH);
  assign af_n = free > thr;
  assign we   = req && ir;
  assign nxt  = wptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (we) begin
      wptr  <= nxt;
      wgray <= nxt ^ (nxt >> 1);
    end
  end
endmodule

// File: rtl/rtx_fifo_rside.sv
module rtx_fifo_rside
  import rtx_fifo_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW:0]   wsync,
  input  logic          req,
  input  logic          rtm,
  input  logic          rfm,
  input  logic [AW:0]   thr,
  input  logic [DW-1:0] rdat,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] dout,
  output logic          ov,
  output logic          ae_n,
  output logic [AW:0]   pgray,
  output logic [AW:0]   rptr,
  output logic [AW:0]   mark,
  output logic          rt_mode
);
  rd_act_e     act;
  logic        rd_fire, has, rewind;
  logic [AW:0] ov_w, level, lim, pbin, pnxt;

  assign ov_w    = {{AW{1'b0}}, ov};
  assign rd_fire = req && ov;
  assign has     = run && (wsync != rptr);
  assign rewind  = rt_mode && rfm;
  assign raddr   = rewind ? mark[AW-1:0] : rptr[AW-1:0];
  assign level   = (wsync - rptr) + ov_w;
  assign ae_n    = level > thr;
  // oldest location the writer must not reuse
  assign lim     = rt_mode ? mark : (rptr - ov_w);
  assign pnxt    = pbin + 1'b1;

  always_comb begin
    if (rewind)                   act = RD_REWIND;
    else if (has && (!ov || rd_fire)) act = RD_LOAD;
    else                          act = RD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr    <= '0;
      dout    <= '0;
      ov      <= 1'b0;
      mark    <= '0;
      rt_mode <= 1'b0;
      pbin    <= '0;
      pgray   <= '0;
    end else begin
      case (act)
        RD_REWIND: begin
          rptr <= mark + 1'b1;
          dout <= rdat;
          ov   <= 1'b1;
        end
        RD_LOAD: begin
          rptr <= rptr + 1'b1;
          dout <= rdat;
          ov   <= 1'b1;
        end
        default: if (rd_fire) ov <= 1'b0;
      endcase
      if (!rtm) begin
        rt_mode <= 1'b0;
      end else if (!rt_mode && ov) begin
        rt_mode <= 1'b1;
        mark    <= rptr - 1'b1;
      end
      // released space advances one step per edge so the Gray copy moves one bit
      if (pbin != lim) begin
        pbin  <= pnxt;
        pgray <= pnxt ^ (pnxt >> 1);
      end
    end
  end
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo
  import rtx_fifo_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          a_clk,
  input  logic          b_clk,
  input  logic          rst_n,
  input  logic          a_cs_n,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic [DW-1:0] a_data,
  output logic          a_ir,
  output logic          a_af_n,
  input  logic [AW:0]   af_thr,
  input  logic          b_cs_n,
  input  logic          b_en,
  input  logic          b_wr_n,
  output logic [DW-1:0] b_data,
  output logic          b_or,
  output logic          b_ae_n,
  input  logic [AW:0]   ae_thr,
  input  logic          b_rtm,
  input  logic          b_rfm
);
  localparam int DEPTH = 1 << AW;

  logic            w_run, r_run, a_req, b_req, we, rt_mode;
  logic [AW:0]     wptr, wgray, psync, wsync, pgray, rptr, mark;
  logic [AW-1:0]   raddr;
  logic [DW-1:0]   rdat;
  logic [DW-1:0]   mem [DEPTH];

  assign a_req = !a_cs_n && a_en && a_wr;
  assign b_req = !b_cs_n && b_en && b_wr_n;

  rtx_fifo_rstseq #(.EDGES(RST_EDGES)) u_wrst (.clk(a_clk), .rst_n(rst_n), .run(w_run));
  rtx_fifo_rstseq #(.EDGES(RST_EDGES)) u_rrst (.clk(b_clk), .rst_n(rst_n), .run(r_run));

  rtx_fifo_gsync #(.N(AW+1)) u_w2r (.clk(b_clk), .rst_n(rst_n), .gin(wgray), .bout(wsync));
  rtx_fifo_gsync #(.N(AW+1)) u_r2w (.clk(a_clk), .rst_n(rst_n), .gin(pgray), .bout(psync));

  rtx_fifo_wside #(.AW(AW)) u_wside (
    .clk(a_clk), .rst_n(rst_n), .run(w_run), .req(a_req), .psync(psync),
    .thr(af_thr), .wptr(wptr), .wgray(wgray), .ir(a_ir), .af_n(a_af_n), .we(we)
  );

  rtx_fifo_rside #(.AW(AW), .DW(DW)) u_rside (
    .clk(b_clk), .rst_n(rst_n), .run(r_run), .wsync(wsync), .req(b_req),
    .rtm(b_rtm), .rfm(b_rfm), .thr(ae_thr), .rdat(rdat), .raddr(raddr),
    .dout(b_data), .ov(b_or), .ae_n(b_ae_n), .pgray(pgray), .rptr(rptr),
    .mark(mark), .rt_mode(rt_mode)
  );

  always_ff @(posedge a_clk) begin
    if (we) mem[wptr[AW-1:0]] <= a_data;
  end

  assign rdat = mem[raddr];
endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input logic          a_clk,
  input logic          b_clk,
  input logic          rst_n,
  input logic          w_run,
  input logic          r_run,
  input logic          a_req,
  input logic          a_ir,
  input logic          b_req,
  input logic          b_or,
  input logic [DW-1:0] b_data,
  input logic          b_rfm,
  input logic          rt_mode,
  input logic [AW:0]   wptr,
  input logic [AW:0]   wgray,
  input logic [AW:0]   psync,
  input logic [AW:0]   pgray,
  input logic [AW:0]   rptr,
  input logic [AW:0]   mark
);
  localparam logic [AW:0] DEPTH = {1'b1, {AW{1'b0}}};

  p_or_needs_run_r1: assert property (@(posedge b_clk) disable iff (!rst_n)
    !r_run |-> !b_or);

  p_no_overflow_r8: assert property (@(posedge a_clk) disable iff (!rst_n || !w_run)
    (AW+1)'(wptr - psync) <= DEPTH);

  p_full_drops_write_r8: assert property (@(posedge a_clk) disable iff (!rst_n || !w_run)
    (a_req && !a_ir) |=> (wptr == $past(wptr)));

  p_hold_word_r5: assert property (@(posedge b_clk) disable iff (!rst_n || !r_run)
    (b_or && !b_req && !(rt_mode && b_rfm)) |=> (b_or && $stable(b_data)));

  p_rewind_r11: assert property (@(posedge b_clk) disable iff (!rst_n || !r_run)
    (rt_mode && b_rfm) |=> (b_or && (rptr == (AW+1)'($past(mark) + 1'b1))));

  p_wgray_step_r5: assert property (@(posedge a_clk) disable iff (!rst_n || !w_run)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_pgray_step_r12: assert property (@(posedge b_clk) disable iff (!rst_n || !r_run)
    $countones(pgray ^ $past(pgray)) <= 1);
endmodule

bind rtx_fifo rtx_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .a_clk(a_clk), .b_clk(b_clk), .rst_n(rst_n), .w_run(w_run), .r_run(r_run),
  .a_req(a_req), .a_ir(a_ir), .b_req(b_req), .b_or(b_or), .b_data(b_data),
  .b_rfm(b_rfm), .rt_mode(rt_mode), .wptr(wptr), .wgray(wgray), .psync(psync),
  .pgray(pgray), .rptr(rptr), .mark(mark)
);

// File: tb/test_rtx_fifo.sv
module test_rtx_fifo;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic a_clk = 1'b0, b_clk = 1'b0, rst_n = 1'b0;
  logic a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0;
  logic [DW-1:0] a_data = '0;
  logic b_cs_n = 1'b1, b_en = 1'b0, b_wr_n = 1'b1, b_rtm = 1'b0, b_rfm = 1'b0;
  logic [AW:0] ae_thr = '0, af_thr = '0;
  logic a_ir, a_af_n, b_or, b_ae_n;
  logic [DW-1:0] b_data;
  int b_half = 5;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 a_clk = ~a_clk;
  initial forever #(b_half) b_clk = ~b_clk;

  rtx_fifo #(.DW(DW), .AW(AW)) i_rtx_fifo (
    .a_clk(a_clk), .b_clk(b_clk), .rst_n(rst_n), .a_cs_n(a_cs_n), .a_en(a_en),
    .a_wr(a_wr), .a_data(a_data), .a_ir(a_ir), .a_af_n(a_af_n), .af_thr(af_thr),
    .b_cs_n(b_cs_n), .b_en(b_en), .b_wr_n(b_wr_n), .b_data(b_data), .b_or(b_or),
    .b_ae_n(b_ae_n), .ae_thr(ae_thr), .b_rtm(b_rtm), .b_rfm(b_rfm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(negedge a_clk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    a_cs_n = 1'b0; a_en = 1'b1; a_wr = 1'b1; a_data = d;
    @(negedge a_clk);
    a_cs_n = 1'b1; a_en = 1'b0; a_wr = 1'b0;
  endtask

  task automatic rd_expect(input string req, input logic [DW-1:0] exp);
    chk(req, {31'd0, b_or}, 32'd1);
    chk(req, {24'd0, b_data}, {24'd0, exp});
    b_cs_n = 1'b0; b_en = 1'b1; b_wr_n = 1'b1;
    @(negedge b_clk);
    b_cs_n = 1'b1; b_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge a_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    int cnt;
    // R1: reset sequence
    wait_a(2);
    chk("R1 ir in reset", {31'd0, a_ir}, 0);
    chk("R1 or in reset", {31'd0, b_or}, 0);
    wait_a(4);
    rst_n = 1'b1;
    #1 chk("R1 ir before first edge", {31'd0, a_ir}, 0);
    wait_a(1);
    chk("R1 ir after release", {31'd0, a_ir}, 1);
    chk("R1 or after release", {31'd0, b_or}, 0);

    // R4: three-edge output latency (coincident clocks)
    wr(8'hA5);
    wait_a(1); chk("R4 edge1", {31'd0, b_or}, 0);
    wait_a(1); chk("R4 edge2", {31'd0, b_or}, 0);
    wait_a(1); chk("R4 edge3", {31'd0, b_or}, 1);
    rd_expect("R4 data", 8'hA5);
    chk("R3 or low after last word", {31'd0, b_or}, 0);

    // R9: reads on empty are ignored
    b_cs_n = 1'b0; b_en = 1'b1; b_wr_n = 1'b1;
    wait_a(4);
    b_cs_n = 1'b1; b_en = 1'b0;
    wr(8'h3C);
    wait_a(6);
    rd_expect("R9 pointer intact", 8'h3C);
    wait_a(2);
    chk("R9 no phantom word", {31'd0, b_or}, 0);

    // R2: unqualified writes have no effect
    a_cs_n = 1'b1; a_en = 1'b1; a_wr = 1'b1; a_data = 8'h11; wait_a(1);
    a_cs_n = 1'b0; a_en = 1'b0; a_wr = 1'b1; wait_a(1);
    a_cs_n = 1'b0; a_en = 1'b1; a_wr = 1'b0; wait_a(1);
    a_cs_n = 1'b1; a_en = 1'b0; a_wr = 1'b0;
    wait_a(6);
    chk("R2 no write", {31'd0, b_or}, 0);

    // R3: port B write direction consumes nothing
    wr(8'h77);
    wait_a(6);
    b_cs_n = 1'b0; b_en = 1'b1; b_wr_n = 1'b0; wait_a(2);
    b_cs_n = 1'b1; b_en = 1'b1; b_wr_n = 1'b1; wait_a(2);
    b_en = 1'b0;
    chk("R3 word kept", {31'd0, b_or}, 1);
    rd_expect("R3 word", 8'h77);
    wait_a(4);

    // R6 R7 R8: sweep every fill level against every threshold
    for (int n = 0; n <= DEPTH; n++) begin
      wait_a(8);
      for (int x = 0; x <= DEPTH; x++) begin
        ae_thr = x[AW:0];
        #1 chk("R6 almost empty", {31'd0, b_ae_n}, (n > x) ? 1 : 0);
      end
      for (int y = 0; y <= DEPTH; y++) begin
        af_thr = y[AW:0];
        #1 chk("R7 almost full", {31'd0, a_af_n}, ((DEPTH - n) > y) ? 1 : 0);
      end
      chk("R8 ready vs level", {31'd0, a_ir}, (n < DEPTH) ? 1 : 0);
      chk("R5 valid vs level", {31'd0, b_or}, (n > 0) ? 1 : 0);
      @(negedge a_clk);
      if (n < DEPTH) wr(8'h40 + n[7:0]);
    end
    wr(8'hEE);   // R8: attempt while full
    wait_a(4);
    for (int i = 0; i < DEPTH; i++) rd_expect("R5 order after fill", 8'h40 + i[7:0]);
    wait_a(4);
    chk("R8 full write dropped", {31'd0, b_or}, 0);
    wait_a(8);

    // R10 R11 R12: mark on a read edge, rewind, protection
    for (int i = 0; i < 6; i++) wr(8'h10 + i[7:0]);
    wait_a(8);
    chk("R10 head", {24'd0, b_data}, 32'h10);
    b_rtm = 1'b1;
    rd_expect("R10 mark while reading", 8'h10);
    rd_expect("R10 next", 8'h11);
    rd_expect("R10 next", 8'h12);
    b_rfm = 1'b1; wait_a(1); b_rfm = 1'b0;
    chk("R11 rewind valid", {31'd0, b_or}, 1);
    chk("R11 rewind data", {24'd0, b_data}, 32'h10);
    wait_a(8);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (a_ir) begin
        wr(8'h50 + cnt[7:0]);
        cnt++;
      end
    end
    chk("R12 writes up to mark", cnt, DEPTH - 6);
    chk("R12 ready low at mark", {31'd0, a_ir}, 0);
    for (int i = 0; i < 6; i++) rd_expect("R11 replay", 8'h10 + i[7:0]);
    wait_a(8);
    chk("R12 reads do not free", {31'd0, a_ir}, 0);
    b_rtm = 1'b0;
    for (int i = 0; i < DEPTH - 6; i++) rd_expect("R5 after replay", 8'h50 + i[7:0]);
    wait_a(10);
    chk("R10 exit frees space", {31'd0, a_ir}, 1);
    b_rfm = 1'b1; wait_a(1); b_rfm = 1'b0;
    wait_a(2);
    chk("R10 rewind ignored outside mode", {31'd0, b_or}, 0);

    // R1: a reset shorter than four edges does not complete
    rst_n = 1'b0; wait_a(2); rst_n = 1'b1;
    wait_a(3);
    chk("R1 short reset", {31'd0, a_ir}, 0);
    rst_n = 1'b0; wait_a(5); rst_n = 1'b1;
    wait_a(2);
    chk("R1 full reset", {31'd0, a_ir}, 1);

    // R5: streaming with unrelated clocks
    b_half = 7;
    fork
      begin
        int i = 0;
        while (i < 40) begin
          @(negedge a_clk);
          if (a_ir) begin
            a_cs_n = 1'b0; a_en = 1'b1; a_wr = 1'b1; a_data = 8'h80 + i[7:0];
            i++;
          end else begin
            a_cs_n = 1'b1; a_en = 1'b0;
          end
        end
        @(negedge a_clk);
        a_cs_n = 1'b1; a_en = 1'b0; a_wr = 1'b0;
      end
      begin
        int j = 0;
        while (j < 40) begin
          @(negedge b_clk);
          if (b_or) begin
            chk("R5 stream order", {24'd0, b_data}, 32'h80 + j);
            b_cs_n = 1'b0; b_en = 1'b1; b_wr_n = 1'b1;
            j++;
          end else begin
            b_cs_n = 1'b1; b_en = 1'b0;
          end
        end
        @(negedge b_clk);
        b_cs_n = 1'b1; b_en = 1'b0;
      end
    join
    repeat (6) @(negedge b_clk);
    chk("R3 drained", {31'd0, b_or}, 0);

    done = 1'b1;
    report();
  end
endmodule